// File: doc/BRIEF.md
# Strided Vector Load Address Generator

This block turns one scalar-looking LOAD into a run of element reads. Each element goes to the next destination register, and each address is either the next word or the previous address plus a stride. The run length comes from a per-register vector-length table. Two offset-configuration slots can tie a base register to an extra offset amount and to a stride mode. In stride mode the load's immediate becomes the distance between elements instead of a displacement.

A configuration command writes one slot at a time. A slot holds the register it matches, the register bank (integer or float), the stride mode and the offset amount. A separate write port sets the vector length for any (bank, register) pair.

When a load request is accepted, the block takes a snapshot of the matching slot, the length and the start address. It then presents one read per element on a valid/ready memory port. It raises a one-cycle done pulse after the final element is accepted.

Top module: `stride_load_agu`

## Requirements
- R1: After reset the block is idle: `ldReady`=1, `memValid`=0, `done`=0. Both slots are empty (they match nothing), and every vector-length entry reads as 1.
- R2: A configuration command (`cfgValid`=1) writes the slot chosen by `cfgSlot` (0 or 1). It stores the register number, bank (0=integer, 1=float), mode (1=stride, 0=unit) and offset amount, and it replaces whatever that slot held before.
- R3: A slot matches a load when it has been written, its register equals `ldRs` and its bank equals `ldBank`. Slot 0 is tested first, and the first match alone supplies the offset amount and mode.
- R4: For a length greater than 1 with no match, or with a match in unit mode, the first address is `ldBase` + offset + sign-extended `ldImm`. Each later element adds 4. With no match the offset is 0.
- R5: For a length greater than 1 with a matching slot in stride mode, the first address is `ldBase` + offset. Each later element adds the sign-extended 12-bit `ldImm`, so negative strides walk downward.
- R6: The number of reads issued equals the vector length stored for (`ldBank`, `ldRd`). A length write of 0 is stored as 1.
- R7: A length of 1 gives exactly one read at `ldBase` + sign-extended `ldImm`, whatever the slots hold.
- R8: Element i is tagged with destination register (`ldRd` + i) modulo 32.
- R9: While `memValid`=1 and `memReady`=0, the request holds: `memValid` stays 1, and `memAddr` and `memDest` do not change.
- R10: A load is accepted only while `ldReady`=1, and `memValid` rises in the next cycle. `done` is high for exactly one cycle, starting the cycle after the last element's handshake, and `ldReady` is high again in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgValid | input | 1 | Slot configuration write strobe |
| cfgSlot | input | 1 | Slot index being written |
| cfgReg | input | 5 | Base register the slot applies to |
| cfgBank | input | 1 | Slot bank: 0 integer, 1 float |
| cfgMode | input | 1 | 1 stride mode, 0 unit mode |
| cfgAmount | input | 32 | Offset amount added to the base |
| vlValid | input | 1 | Vector-length write strobe |
| vlBank | input | 1 | Bank of the length entry |
| vlReg | input | 5 | Register of the length entry |
| vlLen | input | 4 | Length value (0 stored as 1) |
| ldValid | input | 1 | Load request valid |
| ldReady | output | 1 | Block idle, load accepted this cycle |
| ldBank | input | 1 | Bank of the load |
| ldRd | input | 5 | First destination register |
| ldRs | input | 5 | Base register number (for slot match) |
| ldBase | input | 32 | Base register value |
| ldImm | input | 12 | Signed immediate |
| memValid | output | 1 | Element read request valid |
| memReady | input | 1 | Memory accepts the request |
| memAddr | output | 32 | Element byte address |
| memDest | output | 5 | Destination register of the element |
| done | output | 1 | One-cycle pulse after the final element |

## Verification
The first element appears one cycle after the load handshake, because the start address passes through one register. Each later element appears one cycle after the previous element's handshake. `done` follows one cycle after the last handshake.

The bench drives inputs on the falling edge and samples on the next falling edge, so every check lands exactly one register stage after its cause. Stall cycles are mixed in at fixed element positions. Those cycles check that the address and destination are held, and each later check waits for the real handshake edge rather than a fixed element count.

// File: rtl/stride_load_pkg.sv
`timescale 1ns/1ps
package stride_load_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic capture;  // snapshot a new load
    logic advance;  // current element accepted, step to next
  } aguStrobe_t;

  localparam logic BANK_INT  = 1'b0;
  localparam logic BANK_FLT  = 1'b1;
  localparam logic MODE_UNIT = 1'b0;
  localparam logic MODE_STRD = 1'b1;
endpackage

// File: rtl/stride_load_ctrl.sv
`timescale 1ns/1ps
module stride_load_ctrl
  import stride_load_pkg::*;
#(
  parameter int VL_W = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            ldValid,
  input  logic            memReady,
  input  logic [VL_W-1:0] lenSel,
  output logic            ldReady,
  output logic            memValid,
  output logic            done,
  output aguStrobe_t      strobe
);
  typedef enum logic {ST_IDLE, ST_ISSUE} state_t;

  state_t          state;
  logic [VL_W-1:0] remaining;
  logic            lastElem;

  assign ldReady        = (state == ST_IDLE);
  assign memValid       = (state == ST_ISSUE);
  assign strobe.capture = ldReady && ldValid;
  assign strobe.advance = memValid && memReady;
  assign lastElem       = (remaining == VL_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      remaining <= '0;
      done      <= 1'b0;
    end else begin
      done <= strobe.advance && lastElem;
      unique case (state)
        ST_IDLE: begin
          if (strobe.capture) begin
            state     <= ST_ISSUE;
            remaining <= lenSel;
          end
        end
        ST_ISSUE: begin
          if (strobe.advance) begin
            remaining <= remaining - VL_W'(1);
            if (lastElem) state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/stride_load_dp.sv
`timescale 1ns/1ps
module stride_load_dp
  import stride_load_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int REG_W      = 5,
  parameter int VL_W       = 4,
  parameter int IMM_W      = 12,
  parameter int NUM_SLOTS  = 2,
  parameter int ELEM_BYTES = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  aguStrobe_t       strobe,
  input  logic             cfgValid,
  input  logic [$clog2(NUM_SLOTS)-1:0] cfgSlot,
  input  logic [REG_W-1:0] cfgReg,
  input  logic             cfgBank,
  input  logic             cfgMode,
  input  logic [XLEN-1:0]  cfgAmount,
  input  logic             vlValid,
  input  logic             vlBank,
  input  logic [REG_W-1:0] vlReg,
  input  logic [VL_W-1:0]  vlLen,
  input  logic             ldBank,
  input  logic [REG_W-1:0] ldRd,
  input  logic [REG_W-1:0] ldRs,
  input  logic [XLEN-1:0]  ldBase,
  input  logic [IMM_W-1:0] ldImm,
  output logic [VL_W-1:0]  lenSel,
  output logic [XLEN-1:0]  memAddr,
  output logic [REG_W-1:0] memDest
);
  localparam int NREG    = 1 << REG_W;
  localparam int VL_ENTS = 2 * NREG;
  localparam int SEL_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

  // ---------------- offset-configuration slots ----------------
  logic             slotUsed [NUM_SLOTS];
  logic [REG_W-1:0] slotReg  [NUM_SLOTS];
  logic             slotBank [NUM_SLOTS];
  logic             slotMode [NUM_SLOTS];
  logic [XLEN-1:0]  slotAmt  [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] slotHit;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : gSlot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        slotUsed[s] <= 1'b0;
        slotReg[s]  <= '0;
        slotBank[s] <= BANK_INT;
        slotMode[s] <= MODE_UNIT;
        slotAmt[s]  <= '0;
      end else if (cfgValid && (int'(cfgSlot) == s)) begin
        slotUsed[s] <= 1'b1;
        slotReg[s]  <= cfgReg;
        slotBank[s] <= cfgBank;
        slotMode[s] <= cfgMode;
        slotAmt[s]  <= cfgAmount;
      end
    end
    assign slotHit[s] = slotUsed[s] && (slotReg[s] == ldRs) && (slotBank[s] == ldBank);
  end

  // lowest-numbered matching slot wins
  logic [SEL_W-1:0] hitSel;
  logic             anyHit;
  always_comb begin
    hitSel = '0;
    anyHit = 1'b0;
    for (int s = NUM_SLOTS - 1; s >= 0; s--) begin
      if (slotHit[s]) begin
        hitSel = SEL_W'(s);
        anyHit = 1'b1;
      end
    end
  end

  // ---------------- vector-length table ----------------
  logic [VL_W-1:0] vlMem [VL_ENTS];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int e = 0; e < VL_ENTS; e++) vlMem[e] <= VL_W'(1);
    end else if (vlValid) begin
      vlMem[{vlBank, vlReg}] <= (vlLen == '0) ? VL_W'(1) : vlLen;
    end
  end

  assign lenSel = vlMem[{ldBank, ldRd}];

  // ---------------- address generation ----------------
  logic [XLEN-1:0] immExt, offsAmt, startAddr, stepAddr;
  logic            strideMode, scalarLoad;

  assign immExt     = {{(XLEN-IMM_W){ldImm[IMM_W-1]}}, ldImm};
  assign offsAmt    = anyHit ? slotAmt[hitSel] : '0;
  assign strideMode = anyHit && (slotMode[hitSel] == MODE_STRD);
  assign scalarLoad = (lenSel == VL_W'(1));

  always_comb begin
    if (scalarLoad)      startAddr = ldBase + immExt;
    else if (strideMode) startAddr = ldBase + offsAmt;
    else                 startAddr = ldBase + offsAmt + immExt;
    stepAddr = strideMode ? immExt : XLEN'(ELEM_BYTES);
  end

  logic [XLEN-1:0] stepReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memAddr <= '0;
      memDest <= '0;
      stepReg <= '0;
    end else if (strobe.capture) begin
      memAddr <= startAddr;
      memDest <= ldRd;
      stepReg <= stepAddr;
    end else if (strobe.advance) begin
      memAddr <= memAddr + stepReg;
      memDest <= memDest + REG_W'(1);
    end
  end
endmodule

// File: rtl/stride_load_agu.sv
`timescale 1ns/1ps
module stride_load_agu
  import stride_load_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int REG_W      = 5,
  parameter int VL_W       = 4,
  parameter int IMM_W      = 12,
  parameter int ELEM_BYTES = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgValid,
  input  logic             cfgSlot,
  input  logic [REG_W-1:0] cfgReg,
  input  logic             cfgBank,
  input  logic             cfgMode,
  input  logic [XLEN-1:0]  cfgAmount,
  input  logic             vlValid,
  input  logic             vlBank,
  input  logic [REG_W-1:0] vlReg,
  input  logic [VL_W-1:0]  vlLen,
  input  logic             ldValid,
  output logic             ldReady,
  input  logic             ldBank,
  input  logic [REG_W-1:0] ldRd,
  input  logic [REG_W-1:0] ldRs,
  input  logic [XLEN-1:0]  ldBase,
  input  logic [IMM_W-1:0] ldImm,
  output logic             memValid,
  input  logic             memReady,
  output logic [XLEN-1:0]  memAddr,
  output logic [REG_W-1:0] memDest,
  output logic             done
);
  aguStrobe_t      strobe;
  logic [VL_W-1:0] lenSel;

  stride_load_ctrl #(.VL_W(VL_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .ldValid(ldValid), .memReady(memReady),
    .lenSel(lenSel), .ldReady(ldReady), .memValid(memValid),
    .done(done), .strobe(strobe)
  );

  stride_load_dp #(
    .XLEN(XLEN), .REG_W(REG_W), .VL_W(VL_W), .IMM_W(IMM_W),
    .NUM_SLOTS(2), .ELEM_BYTES(ELEM_BYTES)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .cfgValid(cfgValid), .cfgSlot(cfgSlot), .cfgReg(cfgReg),
    .cfgBank(cfgBank), .cfgMode(cfgMode), .cfgAmount(cfgAmount),
    .vlValid(vlValid), .vlBank(vlBank), .vlReg(vlReg), .vlLen(vlLen),
    .ldBank(ldBank), .ldRd(ldRd), .ldRs(ldRs), .ldBase(ldBase), .ldImm(ldImm),
    .lenSel(lenSel), .memAddr(memAddr), .memDest(memDest)
  );
endmodule

// File: rtl/stride_load_chk.sv
`timescale 1ns/1ps
module stride_load_chk #(
  parameter int XLEN  = 32,
  parameter int REG_W = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             ldValid,
  input logic             ldReady,
  input logic             memValid,
  input logic             memReady,
  input logic [XLEN-1:0]  memAddr,
  input logic [REG_W-1:0] memDest,
  input logic             done
);
  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memReady) |=> (memValid && $stable(memAddr) && $stable(memDest)));

  // R8
  dest_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && memReady) |=> (!memValid || memDest == $past(memDest) + REG_W'(1)));

  // R10
  accept_issue_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ldValid && ldReady) |=> memValid);

  // R10
  done_after_hs_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(memValid && memReady));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (ldReady && !memValid));
endmodule

bind stride_load_agu stride_load_chk #(.XLEN(XLEN), .REG_W(REG_W)) chk_i (
  .clk(clk), .rstN(rstN), .ldValid(ldValid), .ldReady(ldReady),
  .memValid(memValid), .memReady(memReady), .memAddr(memAddr),
  .memDest(memDest), .done(done)
);

// File: tb/stride_load_agu_tb_top.sv
`timescale 1ns/1ps
module stride_load_agu_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgValid = 0, cfgSlot = 0, cfgBank = 0, cfgMode = 0;
  logic [4:0]  cfgReg = 0;
  logic [31:0] cfgAmount = 0;
  logic        vlValid = 0, vlBank = 0;
  logic [4:0]  vlReg = 0;
  logic [3:0]  vlLen = 0;
  logic        ldValid = 0, ldBank = 0;
  logic        ldReady;
  logic [4:0]  ldRd = 0, ldRs = 0;
  logic [31:0] ldBase = 0;
  logic [11:0] ldImm = 0;
  logic        memValid, memReady = 0, done;
  logic [31:0] memAddr;
  logic [4:0]  memDest;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  stride_load_agu dut_i (
    .clk(clk), .rstN(rstN),
    .cfgValid(cfgValid), .cfgSlot(cfgSlot), .cfgReg(cfgReg), .cfgBank(cfgBank),
    .cfgMode(cfgMode), .cfgAmount(cfgAmount),
    .vlValid(vlValid), .vlBank(vlBank), .vlReg(vlReg), .vlLen(vlLen),
    .ldValid(ldValid), .ldReady(ldReady), .ldBank(ldBank), .ldRd(ldRd),
    .ldRs(ldRs), .ldBase(ldBase), .ldImm(ldImm),
    .memValid(memValid), .memReady(memReady), .memAddr(memAddr),
    .memDest(memDest), .done(done)
  );

  typedef struct packed {
    logic        doCfg;
    logic        cSlot;
    logic [4:0]  cReg;
    logic        cBank;
    logic        cMode;
    logic [31:0] cAmt;
    logic [3:0]  vl;
    logic        bank;
    logic [4:0]  rd;
    logic [4:0]  rs;
    logic [31:0] base;
    logic [11:0] imm;
    logic [31:0] expFirst;
    logic [31:0] expStep;
    logic [3:0]  expCount;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    // R4 no slot match, contiguous words
    '{1'b0, 1'b0, 5'd0,  1'b0, 1'b0, 32'h0,   4'd4, 1'b0, 5'd8,  5'd2,  32'h1230, 12'h000, 32'h1230, 32'd4,  4'd4},
    // R5 slot0 stride mode, imm 12 is the stride
    '{1'b1, 1'b0, 5'd2,  1'b0, 1'b1, 32'h0,   4'd3, 1'b0, 5'd5,  5'd2,  32'h1000, 12'd12,  32'h1000, 32'd12, 4'd3},
    // R4 slot1 unit mode with offset amount
    '{1'b1, 1'b1, 5'd7,  1'b0, 1'b0, 32'h100, 4'd2, 1'b0, 5'd10, 5'd7,  32'h2000, 12'd8,   32'h2108, 32'd4,  4'd2},
    // R3 both slots match reg2: slot0 wins
    '{1'b1, 1'b1, 5'd2,  1'b0, 1'b0, 32'h40,  4'd2, 1'b0, 5'd1,  5'd2,  32'h3000, 12'd16,  32'h3000, 32'd16, 4'd2},
    // R2 overwrite slot0 with new amount
    '{1'b1, 1'b0, 5'd2,  1'b0, 1'b1, 32'h20,  4'd3, 1'b0, 5'd13, 5'd2,  32'h3800, 12'd8,   32'h3820, 32'd8,  4'd3},
    // R3 float bank does not match integer slots
    '{1'b0, 1'b0, 5'd0,  1'b0, 1'b0, 32'h0,   4'd3, 1'b1, 5'd3,  5'd2,  32'h4000, 12'd4,   32'h4004, 32'd4,  4'd3},
    // R7 length 1 ignores matching slot
    '{1'b0, 1'b0, 5'd0,  1'b0, 1'b0, 32'h0,   4'd1, 1'b0, 5'd20, 5'd2,  32'h5000, 12'd12,  32'h500C, 32'd4,  4'd1},
    // R8 destination wraps past 31, negative imm
    '{1'b0, 1'b0, 5'd0,  1'b0, 1'b0, 32'h0,   4'd4, 1'b0, 5'd30, 5'd9,  32'h6000, 12'hFFC, 32'h5FFC, 32'd4,  4'd4},
    // R5 negative stride
    '{1'b1, 1'b1, 5'd9,  1'b0, 1'b1, 32'h0,   4'd3, 1'b0, 5'd4,  5'd9,  32'h7000, 12'hFF8, 32'h7000, 32'hFFFFFFF8, 4'd3},
    // R3 float-bank slot matches float load
    '{1'b1, 1'b1, 5'd11, 1'b1, 1'b0, 32'h10,  4'd2, 1'b1, 5'd6,  5'd11, 32'h8000, 12'h000, 32'h8010, 32'd4,  4'd2}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic doCfg(input logic s, input logic [4:0] r, input logic b,
                       input logic m, input logic [31:0] a);
    @(negedge clk);
    cfgValid = 1; cfgSlot = s; cfgReg = r; cfgBank = b; cfgMode = m; cfgAmount = a;
    @(negedge clk);
    cfgValid = 0;
  endtask

  task automatic doVl(input logic b, input logic [4:0] r, input logic [3:0] l);
    @(negedge clk);
    vlValid = 1; vlBank = b; vlReg = r; vlLen = l;
    @(negedge clk);
    vlValid = 0;
  endtask

  // issue one load and follow its element stream; stall at positions from seed
  task automatic runLoad(input logic b, input logic [4:0] rd, input logic [4:0] rs,
                         input logic [31:0] base, input logic [11:0] imm,
                         input logic [31:0] first, input logic [31:0] step,
                         input int cnt, input int seed, input string req);
    logic [31:0] expA;
    logic [4:0]  expD;
    @(negedge clk);
    check(ldReady == 1'b1, "R10", "ldReady before load", 32'(ldReady), 32'd1);
    ldValid = 1; ldBank = b; ldRd = rd; ldRs = rs; ldBase = base; ldImm = imm;
    memReady = 0;
    @(negedge clk);
    ldValid = 0;
    check(memValid == 1'b1, "R10", "memValid after accept", 32'(memValid), 32'd1);
    expA = first;
    expD = rd;
    for (int i = 0; i < cnt; i++) begin
      if (((i + seed) % 3) == 1) begin
        memReady = 0;
        @(negedge clk);
        check(memValid == 1'b1, "R9", "memValid held in stall", 32'(memValid), 32'd1);
        check(memAddr == expA, "R9", "addr held in stall", memAddr, expA);
      end
      memReady = 1;
      check(memValid == 1'b1, req, "memValid", 32'(memValid), 32'd1);
      check(memAddr == expA, req, "memAddr", memAddr, expA);
      check(memDest == expD, "R8", "memDest", 32'(memDest), 32'(expD));
      @(negedge clk);
      expA = expA + step;
      expD = expD + 5'd1;
    end
    memReady = 0;
    check(done == 1'b1, "R6", "done after last element", 32'(done), 32'd1);
    check(memValid == 1'b0, "R6", "no extra element", 32'(memValid), 32'd0);
    check(ldReady == 1'b1, "R10", "ldReady with done", 32'(ldReady), 32'd1);
    @(negedge clk);
    check(done == 1'b0, "R10", "done one cycle", 32'(done), 32'd0);
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R10 watchdog expired actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    check(ldReady == 1'b1, "R1", "ldReady", 32'(ldReady), 32'd1);
    check(memValid == 1'b0, "R1", "memValid", 32'(memValid), 32'd0);
    check(done == 1'b0, "R1", "done", 32'(done), 32'd0);
    // R1 default length 1 and empty slots: single access at base+imm
    runLoad(1'b0, 5'd12, 5'd3, 32'h100, 12'd8, 32'h108, 32'd4, 1, 0, "R1");

    for (int v = 0; v < NVEC; v++) begin
      if (VECS[v].doCfg)
        doCfg(VECS[v].cSlot, VECS[v].cReg, VECS[v].cBank, VECS[v].cMode, VECS[v].cAmt);
      doVl(VECS[v].bank, VECS[v].rd, VECS[v].vl);
      runLoad(VECS[v].bank, VECS[v].rd, VECS[v].rs, VECS[v].base, VECS[v].imm,
              VECS[v].expFirst, VECS[v].expStep, int'(VECS[v].expCount), v,
              (VECS[v].expCount == 4'd1) ? "R7" : (VECS[v].expStep == 32'd4 ? "R4" : "R5"));
    end

    // R6 length write of 0 stored as 1
    doVl(1'b0, 5'd14, 4'd0);
    runLoad(1'b0, 5'd14, 5'd3, 32'h200, 12'd4, 32'h204, 32'd4, 1, 1, "R6");

    // R6 maximum length 15 with stalls, rs unmatched
    doVl(1'b0, 5'd16, 4'd15);
    runLoad(1'b0, 5'd16, 5'd20, 32'h9000, 12'd0, 32'h9000, 32'd4, 15, 2, "R6");

    summary();
    $finish;
  end
endmodule